// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Mode-Register Control

This block is a small asynchronous serial transmitter and receiver. A byte-wide register bus configures and feeds it. One 8-bit mode register controls it. The top bit of that register is a master power switch. While power is off, every piece of transfer state is held in reset, the serial output idles high and the receive input is treated as a constant high level. Two further bits enable the transmit half and the receive half, and each half is reset synchronously when its enable is cleared. The remaining bits choose the character format (7 or 8 data bits, parity mode, 1 or 2 stop bits) and how receive errors are signalled.

A programmable divider produces a 16x oversampling tick. One serial bit lasts 16 ticks, so it lasts 16*(div+1) clocks. The divider starts counting only on the second clock after power is switched on. Software writes a byte to the data register. The byte waits in a one-entry buffer until the shifter is free, and is then sent LSB first. The receiver looks for a falling edge and confirms the start bit at mid-period. It samples each later bit at mid-period, then stores the character in a receive buffer and records any parity, framing or overrun errors.

Register map (3-bit address): 0 mode, 1 data (write: transmit byte, read: received byte), 2 receive status, 3 transmit status, 4 divider.

Top module: `serial_ctl`

## Requirements
- R1: After reset the mode register reads 0x01 and the divider reads 0. The receive status and transmit status read 0, and txd is 1.
- R2: While mode bit 7 (power) is 0, txd is 1. The receive status, the transmit status and the receive data register read 0 and stay 0. The mode register keeps whatever was written to it.
- R3: The baud tick never occurs in the first two clock cycles after power goes from 0 to 1. With divider 0, when power and transmit enable are written on one edge and a byte on the next, the start bit appears exactly on the third clock edge after the power write.
- R4: Writing mode bit 6 (transmit enable) to 0 stops any transfer at once: txd goes to 1 and the transmit status reads 0. The receive buffer and receive status keep their values.
- R5: Writing mode bit 5 (receive enable) to 0 abandons a reception in progress, and no character from it is ever stored. The receive buffer and receive status keep their values.
- R6: A frame is a start bit (0), then 8 data bits when mode bit 2 is 1 or 7 when it is 0, sent LSB first, then an optional parity bit, then 1 stop bit (mode bit 1 = 0) or 2 stop bits (mode bit 1 = 1). Each bit lasts 16*(div+1) clocks. A 7-bit character reads back with bit 7 = 0.
- R7: Transmit status bit 1 means a byte waits in the buffer, and bit 0 means the shifter is busy. A data write while bit 1 is set is ignored.
- R8: Receive status bits are: bit 0 parity error, bit 1 framing error (first stop bit is 0), bit 2 overrun (a new character arrives while bit 3 is set), bit 3 buffer full. Reading address 2 clears bits 2..0. Reading address 1 clears bit 3. On overrun, the new character replaces the old one.
- R9: Each received character gives one one-cycle pulse. An error-free character pulses rx_done_irq. A character with an error pulses rx_err_irq when mode bit 0 is 1 and rx_done_irq when it is 0. The two outputs are never high together.
- R10: Writing the mode register with its current value during a transfer does not disturb the frame sent or the character received.
- R11: Parity field mode bits 4:3 is 00 none, 01 zero, 10 odd, 11 even. In zero mode the transmitter sends a parity bit of 0 and the receiver does not check the parity bit it receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on read) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rx_done_irq | output | 1 | Pulse: character received |
| rx_err_irq | output | 1 | Pulse: character received with error (mode bit 0 = 1) |

## Verification
The assertions check on every cycle the following properties. No tick occurs during the two-cycle power-up delay. The transfer flags are clear while transmit enable is 0. Power-off state is clear. The buffered transmit byte is frozen while the buffer is full. txd is high whenever the shifter is idle. A status read empties the error bits, and the two interrupt pulses never coincide. The bench alone can show whole-frame properties. These include the bit order, the parity values and the stop-bit count, compared across random formats in loopback. They also include timing against the divider, dropping a second write, an abandoned reception leaving the buffer alone, the error classification of injected bad frames, and a same-value mode rewrite during a frame.

// File: rtl/serial_ctl.sv
module serial_ctl #(
  parameter int DIVW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_done_irq,
  output logic       rx_err_irq
);
  localparam logic [2:0] A_MODE = 3'd0, A_DATA = 3'd1, A_RXST = 3'd2, A_TXST = 3'd3, A_DIV = 3'd4;

  logic [7:0] mode;
  logic [DIVW-1:0] div, bcnt;
  logic [1:0] warm;
  logic tick, core_rst_n;

  function automatic logic par_bit(input logic [7:0] d, input logic [7:0] m);
    logic [7:0] md;
    md = m[2] ? d : {1'b0, d[6:0]};
    case (m[4:3])
      2'b10:   return ~^md;
      2'b11:   return ^md;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [11:0] build_frame(input logic [7:0] d, input logic [7:0] m);
    logic [11:0] f;
    f = '1;
    f[0] = 1'b0;
    if (m[2]) begin
      f[8:1] = d;
      if (m[4:3] != 2'b00) f[9] = par_bit(d, m);
    end else begin
      f[7:1] = d[6:0];
      if (m[4:3] != 2'b00) f[8] = par_bit(d, m);
    end
    return f;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= 8'h01;
      div  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE) mode <= bus_wdata;
      if (bus_addr == A_DIV)  div  <= bus_wdata[DIVW-1:0];
    end

  assign core_rst_n = rst_n & mode[7];

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) begin
      warm <= 2'b00;
      bcnt <= '0;
    end else begin
      warm <= {warm[0], 1'b1};
      if (warm[1]) bcnt <= (bcnt == div) ? '0 : bcnt + 1'b1;
    end

  assign tick = warm[1] && (bcnt == div);

  // transmit half
  logic [7:0]  tx_buf;
  logic [11:0] tx_sh;
  logic [3:0]  tx_left, tx_sub, tx_n;
  logic        tx_full, tx_busy;

  assign tx_n = 4'd1 + (mode[2] ? 4'd8 : 4'd7) + {3'b0, mode[4:3] != 2'b00} + (mode[1] ? 4'd2 : 4'd1);

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) begin
      tx_buf <= '0; tx_sh <= '1; tx_left <= '0; tx_sub <= '0; tx_full <= 1'b0; tx_busy <= 1'b0;
    end else if (!mode[6]) begin
      tx_sh <= '1; tx_left <= '0; tx_sub <= '0; tx_full <= 1'b0; tx_busy <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_DATA && !tx_full) begin
        tx_buf  <= bus_wdata;
        tx_full <= 1'b1;
      end
      if (tick) begin
        if (tx_busy) begin
          if (tx_sub == 4'd15) begin
            tx_sh   <= {1'b1, tx_sh[11:1]};
            tx_left <= tx_left - 1'b1;
            if (tx_left == 4'd1) tx_busy <= 1'b0;
          end
          tx_sub <= tx_sub + 1'b1;
        end else if (tx_full) begin
          tx_sh   <= build_frame(tx_buf, mode);
          tx_left <= tx_n;
          tx_sub  <= '0;
          tx_busy <= 1'b1;
          tx_full <= 1'b0;
        end
      end
    end

  assign txd = mode[7] ? tx_sh[0] : 1'b1;

  // receive half
  logic [1:0] rx_s;
  logic       rx_in, rx_act, rx_pbit, rx_full;
  logic [3:0] rx_sub, rx_idx, rx_dl, rx_stop;
  logic [7:0] rx_sh, rx_buf, rx_data;
  logic [2:0] rx_err, rx_new;

  assign rx_in   = rx_s[1];
  assign rx_dl   = mode[2] ? 4'd8 : 4'd7;
  assign rx_stop = rx_dl + ((mode[4:3] != 2'b00) ? 4'd2 : 4'd1);
  assign rx_data = mode[2] ? rx_sh : {1'b0, rx_sh[7:1]};
  assign rx_new  = {rx_full && !(bus_rd && bus_addr == A_DATA), !rx_in,
                    mode[4] && (rx_pbit != par_bit(rx_data, mode))};

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) rx_s <= 2'b11;
    else             rx_s <= {rx_s[0], rxd};

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) begin
      rx_act <= 1'b0; rx_sub <= '0; rx_idx <= '0; rx_sh <= '0; rx_pbit <= 1'b0;
      rx_buf <= '0; rx_full <= 1'b0; rx_err <= '0; rx_done_irq <= 1'b0; rx_err_irq <= 1'b0;
    end else begin
      rx_done_irq <= 1'b0;
      rx_err_irq  <= 1'b0;
      if (bus_rd && bus_addr == A_RXST) rx_err  <= '0;
      if (bus_rd && bus_addr == A_DATA) rx_full <= 1'b0;
      if (!mode[5]) begin
        rx_act <= 1'b0; rx_sub <= '0; rx_idx <= '0;
      end else if (tick) begin
        if (!rx_act) begin
          if (!rx_in) begin
            rx_act <= 1'b1; rx_sub <= '0; rx_idx <= '0;
          end
        end else begin
          rx_sub <= rx_sub + 1'b1;
          if (rx_sub == 4'd7) begin
            if (rx_idx == 4'd0) begin
              if (rx_in) rx_act <= 1'b0;
              else       rx_idx <= 4'd1;
            end else if (rx_idx <= rx_dl) begin
              rx_sh  <= {rx_in, rx_sh[7:1]};
              rx_idx <= rx_idx + 1'b1;
            end else if (rx_idx != rx_stop) begin
              rx_pbit <= rx_in;
              rx_idx  <= rx_idx + 1'b1;
            end else begin
              rx_act  <= 1'b0;
              rx_buf  <= rx_data;
              rx_full <= 1'b1;
              rx_err  <= ((bus_rd && bus_addr == A_RXST) ? 3'b0 : rx_err) | rx_new;
              if (rx_new != 3'b0 && mode[0]) rx_err_irq  <= 1'b1;
              else                           rx_done_irq <= 1'b1;
            end
          end
        end
      end
    end

  always_comb
    case (bus_addr)
      A_MODE:  bus_rdata = mode;
      A_DATA:  bus_rdata = rx_buf;
      A_RXST:  bus_rdata = {4'b0, rx_full, rx_err};
      A_TXST:  bus_rdata = {6'b0, tx_full, tx_busy};
      A_DIV:   bus_rdata = {{(8-DIVW){1'b0}}, div};
      default: bus_rdata = 8'h00;
    endcase

  a_r2_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[7] |-> (rx_err == 3'b0 && !rx_full && !tx_full && !tx_busy && txd));
  a_r3_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode[7], 2) |-> !tick);
  a_r4_txe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[6] |=> (!tx_busy && !tx_full));
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |=> (!mode[7] || tx_buf == $past(tx_buf)));
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXST && !tick) |=> rx_err == 3'b0);
  a_r9_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done_irq && rx_err_irq));
endmodule

// File: tb/tb_serial_ctl.sv
module tb_serial_ctl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_wr, bus_rd, rxd, txd, rx_done_irq, rx_err_irq, loop, drv;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  int n_chk = 0, n_fail = 0, cnt_done = 0, cnt_err = 0, bitlen = 16;
  bit finished = 0;

  assign rxd = loop ? txd : drv;

  serial_ctl dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd),
    .rx_done_irq(rx_done_irq), .rx_err_irq(rx_err_irq));

  always @(posedge clk) begin
    if (rx_done_irq) cnt_done++;
    if (rx_err_irq)  cnt_err++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic int nbits(input logic [7:0] m);
    return 1 + (m[2] ? 8 : 7) + ((m[4:3] != 2'b00) ? 1 : 0) + (m[1] ? 2 : 1);
  endfunction

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [7:0] m);
    logic [11:0] f; int k; int ones; int dl;
    dl = m[2] ? 8 : 7; f = '1; f[0] = 1'b0; k = 1; ones = 0;
    for (int i = 0; i < dl; i++) begin f[k] = d[i]; ones += int'(d[i]); k++; end
    case (m[4:3])
      2'b01: f[k] = 1'b0;
      2'b10: f[k] = (ones % 2 == 0);
      2'b11: f[k] = (ones % 2 == 1);
      default: ;
    endcase
    return f;
  endfunction

  task automatic capture(input int n, output logic [11:0] f);
    int t = 0;
    f = '1;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    repeat (bitlen / 2) @(negedge clk);
    f[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (bitlen) @(negedge clk);
      f[i] = txd;
    end
  endtask

  task automatic send_rx(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin drv = f[i]; repeat (bitlen) @(negedge clk); end
    drv = 1'b1;
    repeat (bitlen) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] v, m, d;
    logic [11:0] f, mask;
    int n, dd, de;
    void'($urandom(32'd2024));
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; loop = 0; drv = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 mode reset", v, 8'h01);
    rd(3'd4, v); chk("R1 div reset", v, 8'h00);
    rd(3'd2, v); chk("R1 rx status reset", v, 8'h00);
    rd(3'd3, v); chk("R1 tx status reset", v, 8'h00);
    chk("R1 txd idle", txd, 1'b1);

    // R3: power-up start delay with divider 0
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'hC5; bus_wr = 1'b1;
    @(negedge clk); bus_addr = 3'd1; bus_wdata = 8'h5A;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk); chk("R3 no start before third edge", txd, 1'b1);
    @(negedge clk); chk("R3 start on third edge", txd, 1'b0);

    // R2: power off mid-frame
    wr(3'd0, 8'h45);
    chk("R2 txd high when off", txd, 1'b1);
    rd(3'd3, v); chk("R2 tx status off", v, 8'h00);
    rd(3'd0, v); chk("R2 mode retained", v, 8'h45);

    wr(3'd4, 8'd1); bitlen = 32;
    loop = 1;
    for (int it = 0; it < 16; it++) begin
      m = {3'b111, 5'($urandom)};
      d = 8'($urandom);
      wr(3'd0, m);
      dd = cnt_done;
      wr(3'd1, d);
      n = nbits(m);
      capture(n, f);
      mask = (12'h1 << n) - 12'h1;
      chk((m[4:3] == 2'b01) ? "R11 zero parity frame" : "R6 frame bits", f & mask, exp_frame(d, m) & mask);
      repeat (8) @(negedge clk);
      rd(3'd2, v); chk("R8 status after clean frame", v, 8'h08);
      rd(3'd1, v); chk("R6 received data", v, m[2] ? d : {1'b0, d[6:0]});
      chk("R9 one done pulse", cnt_done, dd + 1);
    end

    // R7: write while full ignored
    wr(3'd0, 8'hE5);
    wr(3'd1, 8'h11);
    wr(3'd1, 8'h22);
    repeat (4) @(negedge clk);
    wr(3'd1, 8'h33);
    wr(3'd1, 8'h44);
    rd(3'd3, v); chk("R7 full and busy", v, 8'h03);
    capture(10, f); chk("R7 first frame", f[9:0], exp_frame(8'h11, 8'hE5) & 12'h3FF);
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk("R7 first byte", v, 8'h11);
    capture(10, f); chk("R7 second frame", f[9:0], exp_frame(8'h33, 8'hE5) & 12'h3FF);
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk("R7 second byte", v, 8'h33);
    repeat (bitlen * 12) @(negedge clk);
    rd(3'd2, v); chk("R7 dropped write never sent", v, 8'h00);
    rd(3'd3, v); chk("R7 tx idle", v, 8'h00);

    // R10: same-value rewrite mid-frame
    wr(3'd1, 8'h6C);
    fork
      capture(10, f);
      begin repeat (bitlen * 3) @(negedge clk); wr(3'd0, 8'hE5); end
    join
    chk("R10 frame undisturbed", f[9:0], exp_frame(8'h6C, 8'hE5) & 12'h3FF);
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk("R10 data undisturbed", v, 8'h6C);

    // R4: transmit enable cleared mid-frame
    loop = 0;
    send_rx(exp_frame(8'h96, 8'hE5), 10);
    wr(3'd1, 8'h3C);
    repeat (bitlen * 3) @(negedge clk);
    wr(3'd0, 8'hA5);
    chk("R4 txd high after txe off", txd, 1'b1);
    rd(3'd3, v); chk("R4 tx status cleared", v, 8'h00);
    rd(3'd2, v); chk("R4 rx status kept", v, 8'h08);
    rd(3'd1, v); chk("R4 rx data kept", v, 8'h96);
    wr(3'd0, 8'hE5);
    repeat (bitlen * 12) @(negedge clk);
    chk("R4 aborted byte not resent", txd, 1'b1);

    // R5: receive enable cleared mid-reception
    send_rx(exp_frame(8'h5A, 8'hE5), 10);
    drv = 1'b0;
    repeat (bitlen * 3) @(negedge clk);
    wr(3'd0, 8'hC5);
    drv = 1'b1;
    repeat (bitlen * 12) @(negedge clk);
    wr(3'd0, 8'hE5);
    repeat (bitlen * 12) @(negedge clk);
    rd(3'd2, v); chk("R5 no frame stored, no overrun", v, 8'h08);
    rd(3'd1, v); chk("R5 buffer kept", v, 8'h5A);

    // R8/R9: parity error with separate error pulse
    wr(3'd0, 8'hFD);
    dd = cnt_done; de = cnt_err;
    send_rx(exp_frame(8'h03, 8'hFD) ^ 12'h200, 11);
    chk("R9 error pulse", cnt_err, de + 1);
    chk("R9 no done pulse on error", cnt_done, dd);
    rd(3'd2, v); chk("R8 parity error", v, 8'h09);
    rd(3'd2, v); chk("R8 cleared by read", v, 8'h08);
    rd(3'd1, v); chk("R8 parity error data", v, 8'h03);

    // R8: framing error
    wr(3'd0, 8'hE5);
    send_rx(exp_frame(8'h81, 8'hE5) & 12'hDFF, 10);
    rd(3'd2, v); chk("R8 framing error", v, 8'h0A);
    rd(3'd1, v); chk("R8 framing data", v, 8'h81);

    // R8: overrun, new byte replaces old
    send_rx(exp_frame(8'h11, 8'hE5), 10);
    send_rx(exp_frame(8'h22, 8'hE5), 10);
    rd(3'd2, v); chk("R8 overrun", v, 8'h0C);
    rd(3'd1, v); chk("R8 overrun keeps newest", v, 8'h22);

    // R9: errors routed to done pulse when mode bit 0 is 0
    wr(3'd0, 8'hE4);
    dd = cnt_done; de = cnt_err;
    send_rx(exp_frame(8'h47, 8'hE4) & 12'hDFF, 10);
    chk("R9 error on done pulse", cnt_done, dd + 1);
    chk("R9 no error pulse", cnt_err, de);
    rd(3'd2, v); rd(3'd1, v);

    // R11: zero parity not checked on receive
    wr(3'd0, 8'hED);
    send_rx(exp_frame(8'h7E, 8'hED) | 12'h200, 11);
    rd(3'd2, v); chk("R11 zero parity unchecked", v, 8'h08);
    rd(3'd1, v); chk("R11 zero parity data", v, 8'h7E);

    // R2: power off clears status and buffer
    wr(3'd0, 8'hE5);
    send_rx(exp_frame(8'hA7, 8'hE5), 10);
    wr(3'd1, 8'h55);
    repeat (bitlen * 2) @(negedge clk);
    wr(3'd0, 8'h65);
    chk("R2 txd high", txd, 1'b1);
    rd(3'd3, v); chk("R2 tx status cleared", v, 8'h00);
    rd(3'd2, v); chk("R2 rx status cleared", v, 8'h00);
    rd(3'd1, v); chk("R2 rx buffer cleared", v, 8'h00);
    wr(3'd0, 8'hE5);
    rd(3'd2, v); chk("R2 still clear after power on", v, 8'h00);

    finished = 1;
    summary();
  end
endmodule